// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block is the acquisition controller of a multichannel analog-input card, described at the register level. A host uses a small 16-bit register port to set up a channel interval, a gain code for each channel and the trigger sources. It then collects results from a sample FIFO. Each conversion is requested from an abstracted converter on a start/done handshake. The converter receives the channel number and that channel's gain code with the request.

A conversion is started by a software write, by a pulse from an internal pacer, or by a pulse on an external trigger pin. Any enabled source can start one. The pacer can optionally be gated by an external level. Successive conversions walk the channel interval and wrap from the last channel back to the first. Every result is pushed into the FIFO together with its channel number, so the host can check that no sample was lost. The FIFO reports empty, half-full and full. An interrupt can be raised on every stored sample or only when the FIFO reaches half-full, and it stays up until the host clears it.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the FIFO is empty, the interrupt is low, the control bits are 0, the scan interval is channel 0 only (scan read = 0x0000), and every gain code is 0. With nothing enabled, the status read (offset 6) is 0x0100.
- R2: Control is written at offset 6. Control bit0 enables the software trigger. A write to offset 0 starts one conversion only while bit0 is 1; with bit0 at 0 the write stores no sample.
- R3: Control bit1 enables the pacer pulse and bit2 enables the external trigger pulse. A pulse from any enabled source starts one conversion, and a pulse from a disabled source does nothing. While bit3 is 1, pacer pulses are accepted only when the gate input is high.
- R4: A trigger that arrives while a conversion is in progress is ignored, so one conversion yields exactly one sample.
- R5: The scan register at offset 4 holds the first channel in bits 3:0 and the last channel in bits 11:8, and it reads back with the same layout. Writing it makes the first channel current. After each conversion the next channel is current+1 modulo 16, or the first channel if current equals last.
- R6: Each FIFO word holds the channel in bits 15:12 and the 12-bit result in bits 11:0. A read at offset 0 returns the oldest word and removes it, and reads 0 while the FIFO is empty.
- R7: A write to offset 2 stores bits 4:0 as the gain code of the selected channel, but only while the first and last channels are equal; otherwise it is ignored. The converter is given the gain code of the channel being converted.
- R8: The status read at offset 6 returns control bits 6:0 in bits 6:0, FIFO empty in bit8, half-full in bit9, full in bit10 and interrupt pending in bit11.
- R9: Half-full is set while the count is at least DEPTH/2, and full is set at DEPTH. A sample completing while the FIFO is full is dropped.
- R10: With control bit4 = 1 and bit5 = 0, every stored sample sets the pending interrupt. With bit4 = 0, nothing sets it.
- R11: With bit4 = 1 and bit5 = 1, the pending interrupt is set only when the FIFO count rises to DEPTH/2.
- R12: The interrupt output follows the pending bit. The bit stays set until any write to offset 8, and a qualifying event in the same cycle as that write leaves it set.
- R13: A write to offset 9 empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at offset 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pacer_tick | input | 1 | Internal pacer pulse |
| ext_trig | input | 1 | External trigger pulse |
| ext_gate | input | 1 | External gate level for the pacer |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | CHW | Channel to convert |
| conv_gain | output | GAIN_W | Gain code for that channel |
| conv_done | input | 1 | Conversion complete pulse |
| conv_result | input | RES_W | Conversion result |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle. A converter result completing sets the pending interrupt, and a host write to the clear offset removes it. The bench counts register stages from the software trigger to the push, and places the clear write exactly on the push cycle. It then judges that the interrupt is still high afterwards. The push and pop paths of the FIFO also meet while sequences are drained, and the bench judges this through exact word order and count.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int DEPTH  = 1024,
  parameter int CHW    = 4,
  parameter int GAIN_W = 5,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              ext_gate,
  output logic              conv_start,
  output logic [CHW-1:0]    conv_chan,
  output logic [GAIN_W-1:0] conv_gain,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);
  localparam int NCH  = 1 << CHW;
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int WW   = CHW + RES_W;
  localparam int HALF = DEPTH / 2;
  localparam logic [3:0] A_DATA = 4'd0, A_GAIN = 4'd2, A_SCAN = 4'd4,
                         A_CTRL = 4'd6, A_CLRI = 4'd8, A_CLRF = 4'd9;

  logic [6:0]        ctrl_q;
  logic [CHW-1:0]    first_q, last_q, cur_q;
  logic [GAIN_W-1:0] gain_q [NCH];
  logic              busy_q, pend_q;
  logic [WW-1:0]     mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;

  logic wr_data, wr_gain, wr_scan, wr_ctrl, wr_clri, wr_clrf, rd_data;
  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign wr_gain = reg_wr && reg_addr == A_GAIN;
  assign wr_scan = reg_wr && reg_addr == A_SCAN;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_clri = reg_wr && reg_addr == A_CLRI;
  assign wr_clrf = reg_wr && reg_addr == A_CLRF;
  assign rd_data = reg_rd && reg_addr == A_DATA;

  logic unused_wd;
  assign unused_wd = ^reg_wdata;

  logic empty, half, full, trig, finish, push, pop, half_evt, evt;
  assign empty = cnt_q == '0;
  assign full  = cnt_q == CW'(DEPTH);
  assign half  = cnt_q >= CW'(HALF);

  assign trig = (ctrl_q[0] & wr_data)
              | (ctrl_q[1] & pacer_tick & (~ctrl_q[3] | ext_gate))
              | (ctrl_q[2] & ext_trig);

  assign conv_start = trig & ~busy_q;
  assign conv_chan  = cur_q;
  assign conv_gain  = gain_q[cur_q];

  assign finish   = busy_q & conv_done;
  assign push     = finish & ~full & ~wr_clrf;
  assign pop      = rd_data & ~empty & ~wr_clrf;
  assign half_evt = push & ~pop & (cnt_q == CW'(HALF - 1));
  assign evt      = ctrl_q[4] & (ctrl_q[5] ? half_evt : push);
  assign irq      = pend_q;

  logic [CHW-1:0] nxt_chan;
  assign nxt_chan = (cur_q == last_q) ? first_q : cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      cur_q   <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < NCH; i++) gain_q[i] <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[6:0];
      if (wr_gain && first_q == last_q) gain_q[first_q] <= reg_wdata[GAIN_W-1:0];

      if (conv_start)  busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;

      if (wr_scan) begin
        first_q <= reg_wdata[CHW-1:0];
        last_q  <= reg_wdata[8 +: CHW];
        cur_q   <= reg_wdata[CHW-1:0];
      end else if (finish) begin
        cur_q <= nxt_chan;
      end

      if (wr_clrf) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push) wp_q <= wp_q + 1'b1;
        if (pop)  rp_q <= rp_q + 1'b1;
        cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end

      if (evt)          pend_q <= 1'b1;
      else if (wr_clri) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= {cur_q, conv_result};
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = empty ? 16'h0000 : 16'(mem[rp_q]);
      A_SCAN:  reg_rdata = {{(8-CHW){1'b0}}, last_q, {(8-CHW){1'b0}}, first_q};
      A_CTRL:  reg_rdata = {4'b0000, pend_q, full, half, empty, 1'b0, ctrl_q};
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          conv_start,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [CW-1:0] fifo_cnt
);
  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 4'd8)) |=> irq);

  // R4
  one_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  // R13
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd9) |=> fifo_cnt == '0);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .conv_start(conv_start),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .fifo_cnt(cnt_q)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int DEPTH = 1024;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic pacer_tick = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
  logic conv_start, conv_done, irq;
  logic [3:0] conv_chan;
  logic [4:0] conv_gain;
  logic [11:0] conv_result;

  adc_scan_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
    .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [11:0] fres(input logic [3:0] ch, input logic [4:0] g);
    return {g, 3'b101, ch};
  endfunction

  logic d1 = 1'b0, d2 = 1'b0;
  logic [11:0] r1 = '0, r2 = '0;
  always_ff @(posedge clk) begin
    d1 <= conv_start;
    if (conv_start) r1 <= fres(conv_chan, conv_gain);
    d2 <= d1;
    r2 <= r1;
  end
  assign conv_done = d2;
  assign conv_result = r2;

  int checks = 0, fails = 0, nstart = 0, cyc = 0;
  always @(posedge clk) begin
    if (conv_start) nstart++;
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired");
      fails++;
      checks++;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic trig_sw();
    wr(4'd0, 16'h0000);
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) pacer_tick = 1'b1; else ext_trig = 1'b1;
    @(negedge clk);
    pacer_tick = 1'b0; ext_trig = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic drain(output int n);
    logic [15:0] s, x;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd6, s);
      if (s[8]) break;
      rd(4'd0, x);
      n++;
    end
  endtask

  localparam logic [23:0] VEC [4] = '{
    {16'h0502, 8'd7}, {16'h0F0D, 8'd5}, {16'h0303, 8'd3}, {16'h020E, 8'd8}
  };

  logic [4:0] gexp [16];
  logic [15:0] v;
  int n;

  initial begin
    for (int i = 0; i < 16; i++) gexp[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd6, v); chk("R1 R8 status", v, 16'h0100);
    rd(4'd4, v); chk("R1 scan", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    trig_sw();
    rd(4'd6, v); chk("R2 sw disabled", v, 16'h0100);

    wr(4'd6, 16'h0001);
    wr(4'd4, 16'h0303); wr(4'd2, 16'h0013); gexp[3] = 5'h13;
    wr(4'd4, 16'h0E0E); wr(4'd2, 16'h000A); gexp[14] = 5'h0A;
    wr(4'd4, 16'h0000); wr(4'd2, 16'h0001); gexp[0] = 5'h01;
    wr(4'd4, 16'h0502); wr(4'd2, 16'h001F);
    rd(4'd4, v); chk("R5 scan readback", v, 16'h0502);

    for (int vi = 0; vi < 4; vi++) begin
      logic [15:0] sw;
      logic [3:0] f, l, ch;
      sw = VEC[vi][23:8];
      f = sw[3:0]; l = sw[11:8]; ch = f;
      wr(4'd4, sw);
      for (int k = 0; k < int'(VEC[vi][7:0]); k++) trig_sw();
      for (int k = 0; k < int'(VEC[vi][7:0]); k++) begin
        rd(4'd0, v);
        chk("R5 R6 R7 sample", v, {ch, fres(ch, gexp[ch])});
        ch = (ch == l) ? f : ch + 4'd1;
      end
    end
    rd(4'd0, v); chk("R6 empty read", v, 16'h0000);

    n = nstart;
    wr(4'd0, 16'h0); wr(4'd0, 16'h0);
    repeat (5) @(posedge clk);
    chk("R4 starts", 16'(nstart - n), 16'd1);
    drain(n); chk("R4 samples", 16'(n), 16'd1);

    wr(4'd6, 16'h0006);
    pulse(0); pulse(1);
    drain(n); chk("R3 pacer+ext", 16'(n), 16'd2);
    wr(4'd6, 16'h0001);
    pulse(0); pulse(1);
    drain(n); chk("R3 disabled", 16'(n), 16'd0);
    wr(4'd6, 16'h000A);
    ext_gate = 1'b0; pulse(0);
    drain(n); chk("R3 gate low", 16'(n), 16'd0);
    ext_gate = 1'b1; pulse(0);
    drain(n); chk("R3 gate high", 16'(n), 16'd1);

    wr(4'd6, 16'h0001);
    trig_sw(); trig_sw();
    wr(4'd9, 16'h0);
    rd(4'd6, v); chk("R13 cleared", v, 16'h0101);

    trig_sw();
    chk("R10 disabled irq", {15'b0, irq}, 16'h0000);
    wr(4'd6, 16'h0011);
    trig_sw();
    chk("R10 every sample", {15'b0, irq}, 16'h0001);
    rd(4'd0, v);
    rd(4'd0, v);
    chk("R12 sticky", {15'b0, irq}, 16'h0001);
    wr(4'd8, 16'h0);
    chk("R12 cleared", {15'b0, irq}, 16'h0000);

    trig_sw();
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd0;
    @(posedge clk); #1 reg_wr = 1'b0;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd8;
    @(posedge clk); #1 reg_wr = 1'b0;
    #1 chk("R12 set beats clear", {15'b0, irq}, 16'h0001);
    wr(4'd8, 16'h0);
    wr(4'd9, 16'h0);

    wr(4'd6, 16'h0032);
    for (int k = 0; k < DEPTH/2 - 1; k++) pulse(0);
    rd(4'd6, v); chk("R11 R9 below half", v, 16'h0032);
    pulse(0);
    rd(4'd6, v); chk("R11 R9 at half", v, 16'h0A32);
    wr(4'd8, 16'h0);
    for (int k = 0; k < DEPTH/2; k++) pulse(0);
    rd(4'd6, v); chk("R9 R11 full", v, 16'h0632);
    pulse(0); pulse(0);
    wr(4'd6, 16'h0000);
    drain(n); chk("R9 dropped", 16'(n), 16'(DEPTH));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule